// File: doc/BRIEF.md
# Context-Tagged Translation Buffer with Scoped Invalidation

This block is a small, fully associative address translation buffer in which every entry carries a 12-bit process-context tag, a 52-bit virtual page number, a physical frame number and a global flag. Entries are written through a fill port into slots chosen round-robin. A lookup port answers in the same cycle: an entry hits when it is valid, its page number matches, and either its context tag equals the current context or it is marked global.

A command port takes an invalidation request made of a 2-bit scope code and a 128-bit descriptor. The descriptor supplies the context (bits 11:0) and a 64-bit linear address (bits 127:64), whose page number is address bits 63:12. All entries are compared in parallel and the selected valid bits drop at the accepting edge. The scope decides whether the match uses the address, the context, both or neither, and whether global entries are kept. When the `longMode` input is low, every fill, lookup and command is handled as if it carried context 0. Commands are assumed legal. No fault checking is done.

Top module: `ctx_tlb_inval`

## Requirements
- R1: After reset no entry is valid, `cmdBusy` and `cmdDone` are low, and every lookup misses.
- R2: Each fill writes the slot named by a round-robin pointer that starts at 0 and wraps after slot 15, so the 17th fill replaces the entry from the 1st fill.
- R3: `lookupHit` is high in the same cycle as `lookupValid` exactly when a valid entry has the requested page number and either its context equals the effective current context or its global flag is set. `lookupPfn` then carries that entry's frame number. `lookupHit` is low whenever `lookupValid` is low.
- R4: A command is accepted on an edge where `cmdValid` is high and `cmdBusy` is low. `cmdDone` and `cmdBusy` are then high for exactly the following cycle, and a request presented during that cycle is ignored.
- R5: Scope 0 clears entries whose page number and context both match the descriptor. Global entries are never cleared.
- R6: Scope 1 clears every non-global entry whose context matches the descriptor context.
- R7: Scope 2 clears every entry, global or not, with any context.
- R8: Scope 3 clears every non-global entry with any context and keeps all global entries.
- R9: The command context is descriptor bits 11:0 and the page number is descriptor bits 127:76. Descriptor bits 75:64, the page offset, do not affect matching.
- R10: While `longMode` is low, the fill context, the lookup context and the command context are all taken as 0.
- R11: A lookup in the cycle where `cmdDone` is high sees the state after the invalidation.
- R12: A fill on the same edge as an accepted invalidation is written after the clear, so the new entry stays valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| longMode | input | 1 | High when context tags are in force; low forces context 0 |
| curCtx | input | 12 | Current context used by lookups |
| fillValid | input | 1 | Write one entry this cycle |
| fillVpn | input | 52 | Virtual page number of the new entry |
| fillPfn | input | 20 | Frame number of the new entry |
| fillCtx | input | 12 | Context tag of the new entry |
| fillGlobal | input | 1 | Global flag of the new entry |
| lookupValid | input | 1 | Lookup request |
| lookupVpn | input | 52 | Page number to look up |
| lookupHit | output | 1 | Lookup found an entry |
| lookupPfn | output | 20 | Frame number of the hit entry |
| cmdValid | input | 1 | Invalidation request |
| cmdType | input | 2 | Invalidation scope 0..3 |
| cmdDesc | input | 128 | Descriptor: context in 11:0, address in 127:64 |
| cmdBusy | output | 1 | Command port not ready |
| cmdDone | output | 1 | One-cycle completion pulse |

## Verification
The checker watches the handshake on every cycle: a pulse follows each accepted request, it lasts one cycle, and it never appears without a request. It also checks that a hit needs a lookup, that a full flush with no concurrent fill leaves the buffer empty, that the context-scoped and keep-global scopes never drop a global entry, and that a fill always leaves a valid entry. Which entries each scope removes, the round-robin replacement, context forcing outside long mode, page-offset independence and the post-invalidation view in the completion cycle only show up in the bench scenarios. There a reference model predicts every lookup result.

// File: rtl/tlbinv_pkg.sv
package tlbinv_pkg;
  localparam int CTX_W      = 12;
  localparam int ADDR_W     = 64;
  localparam int PAGE_SHIFT = 12;
  localparam int VPN_W      = ADDR_W - PAGE_SHIFT;
  localparam int DESC_W     = 128;
  localparam int ADDR_LSB   = 64;

  typedef enum logic [1:0] {
    KILL_ADDR_CTX = 2'd0,
    KILL_CTX      = 2'd1,
    KILL_ALL      = 2'd2,
    KILL_ALL_KEEP = 2'd3
  } killKind_e;

  typedef struct packed {
    logic              doKill;
    killKind_e         kind;
    logic [CTX_W-1:0]  ctx;
    logic [VPN_W-1:0]  vpn;
  } killStrobe_t;
endpackage

// File: rtl/tlbinv_ctrl.sv
module tlbinv_ctrl
  import tlbinv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              longMode,
  input  logic              cmdValid,
  input  logic [1:0]        cmdType,
  input  logic [DESC_W-1:0] cmdDesc,
  output killStrobe_t       strobe,
  output logic              cmdBusy,
  output logic              cmdDone
);
  typedef enum logic {ST_IDLE, ST_DONE} ctrlState_e;
  ctrlState_e state;
  logic accept;

  assign accept = cmdValid && (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else if (accept) state <= ST_DONE;
    else state <= ST_IDLE;
  end

  always_comb begin
    strobe.doKill = accept;
    strobe.kind   = killKind_e'(cmdType);
    strobe.ctx    = longMode ? cmdDesc[CTX_W-1:0] : '0;
    strobe.vpn    = cmdDesc[ADDR_LSB+PAGE_SHIFT +: VPN_W];
  end

  assign cmdBusy = (state == ST_DONE);
  assign cmdDone = (state == ST_DONE);
endmodule

// File: rtl/tlbinv_dpath.sv
module tlbinv_dpath
  import tlbinv_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int PFN_W   = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              longMode,
  input  killStrobe_t       strobe,
  input  logic [CTX_W-1:0]  curCtx,
  input  logic              fillValid,
  input  logic [VPN_W-1:0]  fillVpn,
  input  logic [PFN_W-1:0]  fillPfn,
  input  logic [CTX_W-1:0]  fillCtx,
  input  logic              fillGlobal,
  input  logic              lookupValid,
  input  logic [VPN_W-1:0]  lookupVpn,
  output logic              lookupHit,
  output logic [PFN_W-1:0]  lookupPfn,
  output logic [ENTRIES-1:0] entryValid,
  output logic [ENTRIES-1:0] entryGlobal
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [VPN_W-1:0] vpnArr [ENTRIES];
  logic [PFN_W-1:0] pfnArr [ENTRIES];
  logic [CTX_W-1:0] ctxArr [ENTRIES];
  logic [IDX_W-1:0] fillPtr;
  logic [ENTRIES-1:0] killMask;
  logic [ENTRIES-1:0] hitVec;
  logic [CTX_W-1:0] effFillCtx;
  logic [CTX_W-1:0] effCurCtx;

  assign effFillCtx = longMode ? fillCtx : '0;
  assign effCurCtx  = longMode ? curCtx  : '0;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    logic vpnEq, ctxEq, writeHere;
    assign vpnEq     = (vpnArr[i] == strobe.vpn);
    assign ctxEq     = (ctxArr[i] == strobe.ctx);
    assign writeHere = fillValid && (fillPtr == IDX_W'(i));

    always_comb begin
      unique case (strobe.kind)
        KILL_ADDR_CTX: killMask[i] = vpnEq && ctxEq && !entryGlobal[i];
        KILL_CTX:      killMask[i] = ctxEq && !entryGlobal[i];
        KILL_ALL:      killMask[i] = 1'b1;
        default:       killMask[i] = !entryGlobal[i];
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        entryValid[i] <= 1'b0;
      end else if (writeHere) begin
        entryValid[i] <= 1'b1;
      end else if (strobe.doKill && killMask[i]) begin
        entryValid[i] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (writeHere) begin
        vpnArr[i]      <= fillVpn;
        pfnArr[i]      <= fillPfn;
        ctxArr[i]      <= effFillCtx;
        entryGlobal[i] <= fillGlobal;
      end
    end

    assign hitVec[i] = lookupValid && entryValid[i] && (vpnArr[i] == lookupVpn)
                       && (entryGlobal[i] || (ctxArr[i] == effCurCtx));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) fillPtr <= '0;
    else if (fillValid) fillPtr <= (fillPtr == IDX_W'(ENTRIES-1)) ? '0 : fillPtr + 1'b1;
  end

  always_comb begin
    lookupPfn = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hitVec[i]) lookupPfn = lookupPfn | pfnArr[i];
    end
  end

  assign lookupHit = |hitVec;
endmodule

// File: rtl/ctx_tlb_inval.sv
module ctx_tlb_inval
  import tlbinv_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int PFN_W   = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              longMode,
  input  logic [11:0]       curCtx,
  input  logic              fillValid,
  input  logic [51:0]       fillVpn,
  input  logic [PFN_W-1:0]  fillPfn,
  input  logic [11:0]       fillCtx,
  input  logic              fillGlobal,
  input  logic              lookupValid,
  input  logic [51:0]       lookupVpn,
  output logic              lookupHit,
  output logic [PFN_W-1:0]  lookupPfn,
  input  logic              cmdValid,
  input  logic [1:0]        cmdType,
  input  logic [127:0]      cmdDesc,
  output logic              cmdBusy,
  output logic              cmdDone
);
  killStrobe_t strobe;
  logic [ENTRIES-1:0] entryValid;
  logic [ENTRIES-1:0] entryGlobal;

  tlbinv_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .longMode(longMode),
    .cmdValid(cmdValid), .cmdType(cmdType), .cmdDesc(cmdDesc),
    .strobe(strobe), .cmdBusy(cmdBusy), .cmdDone(cmdDone)
  );

  tlbinv_dpath #(.ENTRIES(ENTRIES), .PFN_W(PFN_W)) u_dpath (
    .clk(clk), .rst_n(rst_n), .longMode(longMode), .strobe(strobe),
    .curCtx(curCtx), .fillValid(fillValid), .fillVpn(fillVpn),
    .fillPfn(fillPfn), .fillCtx(fillCtx), .fillGlobal(fillGlobal),
    .lookupValid(lookupValid), .lookupVpn(lookupVpn),
    .lookupHit(lookupHit), .lookupPfn(lookupPfn),
    .entryValid(entryValid), .entryGlobal(entryGlobal)
  );
endmodule

// File: rtl/ctx_tlb_inval_chk.sv
module ctx_tlb_inval_chk #(
  parameter int ENTRIES = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               fillValid,
  input logic               lookupValid,
  input logic               lookupHit,
  input logic               cmdValid,
  input logic [1:0]         cmdType,
  input logic               cmdBusy,
  input logic               cmdDone,
  input logic [ENTRIES-1:0] entryValid,
  input logic [ENTRIES-1:0] entryGlobal
);
  AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdValid && !cmdBusy) |=> cmdDone); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmdDone |=> !cmdDone); // R4
  AST_DONE_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmdValid && !cmdBusy) |=> !cmdDone); // R4
  AST_HIT_NEEDS_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
    !lookupValid |-> !lookupHit); // R3
  AST_FLUSH_ALL_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdValid && !cmdBusy && cmdType == 2'd2 && !fillValid) |=> (entryValid == '0)); // R7
  AST_CTX_KEEPS_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdValid && !cmdBusy && cmdType == 2'd1 && !fillValid)
      |=> ((($past(entryValid & entryGlobal)) & ~entryValid) == '0)); // R6
  AST_ALL_KEEPS_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdValid && !cmdBusy && cmdType == 2'd3 && !fillValid)
      |=> ((($past(entryValid & entryGlobal)) & ~entryValid) == '0)); // R8
  AST_FILL_SURVIVES: assert property (@(posedge clk) disable iff (!rst_n)
    fillValid |=> (entryValid != '0)); // R12
endmodule

bind ctx_tlb_inval ctx_tlb_inval_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .fillValid(fillValid),
  .lookupValid(lookupValid), .lookupHit(lookupHit),
  .cmdValid(cmdValid), .cmdType(cmdType), .cmdBusy(cmdBusy), .cmdDone(cmdDone),
  .entryValid(entryValid), .entryGlobal(entryGlobal)
);

// File: tb/ctx_tlb_inval_tb.sv
`timescale 1ns/100ps
module ctx_tlb_inval_tb;
  localparam int N = 16;
  localparam int PW = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic longMode = 1'b1;
  logic [11:0] curCtx = '0;
  logic fillValid = 1'b0;
  logic [51:0] fillVpn = '0;
  logic [PW-1:0] fillPfn = '0;
  logic [11:0] fillCtx = '0;
  logic fillGlobal = 1'b0;
  logic lookupValid = 1'b0;
  logic [51:0] lookupVpn = '0;
  logic lookupHit;
  logic [PW-1:0] lookupPfn;
  logic cmdValid = 1'b0;
  logic [1:0] cmdType = '0;
  logic [127:0] cmdDesc = '0;
  logic cmdBusy, cmdDone;

  always #2.5 clk = ~clk;

  ctx_tlb_inval u_dut (.*);

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [51:0]   mVpn [N];
  logic [PW-1:0] mPfn [N];
  logic [11:0]   mCtx [N];
  logic          mGlb [N];
  logic          mVal [N];
  int            mPtr = 0;

  logic          qHit [$];
  logic [PW-1:0] qPfn [$];
  string         qTag [$];

  function automatic logic [11:0] effCtx(logic [11:0] c);
    return longMode ? c : 12'd0;
  endfunction

  task automatic check(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // monitor: pops expected lookup results
  always @(negedge clk) begin
    if (rst_n && lookupValid && qHit.size() > 0) begin
      logic eh; logic [PW-1:0] ep; string t;
      eh = qHit.pop_front(); ep = qPfn.pop_front(); t = qTag.pop_front();
      check(lookupHit == eh, {t, " hit"}, lookupHit, eh);
      if (eh) check(lookupPfn == ep, {t, " pfn"}, lookupPfn, ep);
    end
  end

  // all tasks start and end 1ns after a rising edge
  task automatic doLookup(logic [51:0] vpn, logic [11:0] ctx, string tag);
    logic eh = 1'b0; logic [PW-1:0] ep = '0;
    for (int i = 0; i < N; i++)
      if (mVal[i] && mVpn[i] == vpn && (mGlb[i] || mCtx[i] == effCtx(ctx))) begin
        eh = 1'b1; ep = mPfn[i];
      end
    qHit.push_back(eh); qPfn.push_back(ep); qTag.push_back(tag);
    lookupValid = 1'b1; lookupVpn = vpn; curCtx = ctx;
    @(posedge clk); #1;
    lookupValid = 1'b0;
  endtask

  task automatic modelFill(logic [51:0] vpn, logic [PW-1:0] pfn, logic [11:0] ctx, logic g);
    mVpn[mPtr] = vpn; mPfn[mPtr] = pfn; mCtx[mPtr] = effCtx(ctx);
    mGlb[mPtr] = g; mVal[mPtr] = 1'b1; mPtr = (mPtr + 1) % N;
  endtask

  task automatic doFill(logic [51:0] vpn, logic [PW-1:0] pfn, logic [11:0] ctx, logic g);
    fillValid = 1'b1; fillVpn = vpn; fillPfn = pfn; fillCtx = ctx; fillGlobal = g;
    @(posedge clk); #1;
    fillValid = 1'b0;
    modelFill(vpn, pfn, ctx, g);
  endtask

  task automatic modelKill(logic [1:0] k, logic [11:0] ctx, logic [51:0] vpn);
    logic [11:0] c = effCtx(ctx);
    for (int i = 0; i < N; i++) begin
      case (k)
        2'd0: if (mVpn[i] == vpn && mCtx[i] == c && !mGlb[i]) mVal[i] = 1'b0;
        2'd1: if (mCtx[i] == c && !mGlb[i]) mVal[i] = 1'b0;
        2'd2: mVal[i] = 1'b0;
        default: if (!mGlb[i]) mVal[i] = 1'b0;
      endcase
    end
  endtask

  // issues a command; holdBusy keeps a scope-2 request up during the busy cycle
  task automatic doCmd(logic [1:0] k, logic [11:0] ctx, logic [63:0] addr,
                       string tag, bit holdBusy);
    check(cmdBusy == 1'b0, "R4 idle before command", cmdBusy, 0);
    cmdValid = 1'b1; cmdType = k; cmdDesc = {addr, 52'd0, ctx};
    @(posedge clk); #1;
    if (holdBusy) cmdType = 2'd2; else cmdValid = 1'b0;
    check(cmdDone == 1'b1 && cmdBusy == 1'b1, "R4 done pulse", {cmdDone, cmdBusy}, 2'b11);
    modelKill(k, ctx, addr[63:12]);
    doLookup(addr[63:12], ctx, {tag, " R11 done-cycle lookup"});
    cmdValid = 1'b0;
    check(cmdDone == 1'b0, "R4 single-cycle done", cmdDone, 0);
  endtask

  initial begin
    #(5.0 * 100000);
    check(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      mVal[i] = 0; mVpn[i] = '0; mPfn[i] = '0; mCtx[i] = '0; mGlb[i] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1
    check(cmdBusy == 0 && cmdDone == 0, "R1 reset handshake", {cmdBusy, cmdDone}, 0);
    doLookup(52'h100, 12'd0, "R1 empty");

    // R2: 17 fills, ctx 1..3, every fifth global
    for (int i = 0; i < 17; i++)
      doFill(52'h100 + i, PW'(20'h1000 + i), 12'(i % 3 + 1), (i % 5) == 0);
    doLookup(52'h100, 12'd1, "R2 oldest replaced");
    doLookup(52'h110, 12'd2, "R2 17th fill");
    doLookup(52'h101, 12'd2, "R3 ctx match");
    doLookup(52'h101, 12'd3, "R3 ctx mismatch");
    doLookup(52'h105, 12'd7, "R3 global any ctx");

    // R5 and R9: page offset bits set in the address
    doCmd(2'd0, 12'd2, {52'h107, 12'hABC}, "R5 addr+ctx", 1'b0);
    doLookup(52'h107, 12'd2, "R5 removed");
    doLookup(52'h104, 12'd2, "R5 other kept");
    doCmd(2'd0, 12'd2, {52'h10A, 12'h000}, "R5 global kept", 1'b0);
    doLookup(52'h10A, 12'd2, "R5 global survives");
    doCmd(2'd0, 12'd3, {52'h101, 12'hFFF}, "R9 wrong ctx", 1'b0);
    doLookup(52'h101, 12'd2, "R9 ctx mismatch keeps");

    // R6, with R4 busy-ignore: scope-2 request held during busy must be dropped
    doCmd(2'd1, 12'd1, 64'h0, "R6 ctx", 1'b1);
    doLookup(52'h103, 12'd1, "R6 ctx1 removed");
    doLookup(52'h10F, 12'd1, "R6 global kept");
    doLookup(52'h104, 12'd2, "R4 held request ignored");

    // R8
    doCmd(2'd3, 12'd0, 64'h0, "R8", 1'b0);
    doLookup(52'h104, 12'd2, "R8 nonglobal removed");
    doLookup(52'h105, 12'd3, "R8 global kept");
    doLookup(52'h10A, 12'd2, "R8 global kept 2");

    // R7
    doCmd(2'd2, 12'd0, 64'h0, "R7", 1'b0);
    doLookup(52'h105, 12'd3, "R7 global removed");
    doLookup(52'h10F, 12'd1, "R7 all removed");

    // R12: fill together with a full flush
    cmdValid = 1'b1; cmdType = 2'd2; cmdDesc = '0;
    fillValid = 1'b1; fillVpn = 52'h200; fillPfn = 20'h2222; fillCtx = 12'd4; fillGlobal = 1'b0;
    @(posedge clk); #1;
    cmdValid = 1'b0; fillValid = 1'b0;
    modelKill(2'd2, 12'd0, 52'd0);
    modelFill(52'h200, 20'h2222, 12'd4, 1'b0);
    check(cmdDone == 1'b1, "R4 done with fill", cmdDone, 1);
    doLookup(52'h200, 12'd4, "R12 fill survives");

    // R10: context forced to 0 outside long mode
    longMode = 1'b0;
    doFill(52'h300, 20'h3333, 12'd5, 1'b0);
    doLookup(52'h300, 12'd9, "R10 lookup ctx ignored");
    doCmd(2'd1, 12'd7, 64'h0, "R10 cmd ctx forced", 1'b0);
    doLookup(52'h300, 12'd0, "R10 removed");
    longMode = 1'b1;
    doLookup(52'h200, 12'd4, "R10 long-mode entry kept");

    repeat (3) @(posedge clk);
    check(qHit.size() == 0, "scoreboard drained", qHit.size(), 0);
    summary();
  end
endmodule